// File: doc/BRIEF.md
# USB Device Mode Control Register

This block holds the one-byte mode register of a full-speed USB device controller and turns its bits into live control signals. A local processor reaches it over a byte-wide command port: command code 0xB8 loads the register from the data byte presented with it, and command code 0xB9 returns the stored byte one cycle later. No other command code touches it.

Most bits are plain levels. They select the DMA width, gate and shape the interrupt output, steer the link LED, and drive the pull-up connect output. Two bits act on a sequence instead of a level. When a write clears the resume-request bit after an earlier write had set it, the block waits a fixed delay and then drives an upstream resume pulse of fixed length. When a write clears the suspend-request bit in the same way, the block enters suspend. The delay, pulse and blink intervals are set in milliseconds against a clock rate given in kHz, so a simulation can shrink them.

A USB bus reset leaves every register bit as it was. The register returns to zero only on the power-on reset.

Top module: `usb_mode_ctl`

## Requirements
- R1: Register bit map, MSB first: bit 7 DMA width, bit 6 resume request, bit 5 suspend request, bit 4 spare (stored and read back), bit 3 interrupt enable, bit 2 debug, bit 1 LED-blink disable, bit 0 connect. A command with `cmd_code` 0xB8 stores `cmd_wdata` at that clock edge. A command with 0xB9 raises `rd_valid` for one cycle after the edge, with `rd_data` equal to the register. Any other code changes nothing and gives no read response.
- R2: After power-on reset the register reads 0x00. `resume_out`, `suspended`, `irq`, `pullup_en` and `dma_wide` are 0, and `led_n` is 1.
- R3: Asserting `bus_reset` never changes any register bit.
- R4: A write that clears bit 6 while bit 6 is stored as 1 starts a resume sequence. `resume_out` rises DELAY cycles after that write edge (DELAY = CLK_KHZ*DELAY_MS) and stays high for PULSE cycles (PULSE = CLK_KHZ*PULSE_MS). A write that clears bit 6 while it is already 0 starts nothing. A new 1-then-0 request made while a sequence is running is ignored.
- R5: A write that clears bit 5 while bit 5 is stored as 1 sets `suspended` at that edge. Writing 1 to bit 5 alone does not. `suspended` clears at the edge after `resume_in` or `bus_reset` is high, and at the edge where a resume pulse ends. A clear wins over a set in the same cycle.
- R6: `irq` is a registered one-cycle result of the event inputs sampled at the previous edge. It is never 1 unless bit 3 was 1 at that edge.
- R7: With bit 2 at 1, `irq` follows `ev_nak` or `ev_err`. With bit 2 at 0, `irq` follows `ev_ack` or `ev_iso`.
- R8: `led_n` is 1 while `enum_ok` is 0. With `enum_ok` at 1 and either bit 1 set or `traffic` low, `led_n` is 0. With `enum_ok` at 1, bit 1 clear and `traffic` high, `led_n` after the m-th edge since `traffic` rose is (m / BLINK) mod 2, where BLINK = CLK_KHZ*BLINK_MS.
- R9: `pullup_en` equals bit 0 when `ext_pullup` is 0. It is 0 whenever `ext_pullup` is 1.
- R10: `dma_wide` equals bit 7 (1 selects a 16-bit DMA width, 0 an 8-bit width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0xB8 write, 0xB9 read) |
| cmd_wdata | input | 8 | Data byte for a write command |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 8 | Register value returned by a read |
| bus_reset | input | 1 | USB bus reset seen on the link |
| resume_in | input | 1 | Resume signalled by the host |
| ext_pullup | input | 1 | Pull-up is handled outside the block |
| enum_ok | input | 1 | Enumeration has completed |
| traffic | input | 1 | USB traffic activity |
| ev_ack | input | 1 | Bulk endpoint ACK event |
| ev_nak | input | 1 | NAK event |
| ev_err | input | 1 | Transfer error event |
| ev_iso | input | 1 | Isochronous transfer done event |
| dma_wide | output | 1 | 16-bit DMA width select |
| pullup_en | output | 1 | Pull-up connect enable |
| resume_out | output | 1 | Upstream resume drive |
| suspended | output | 1 | Suspend state |
| led_n | output | 1 | Active-low link LED |
| irq | output | 1 | Qualified interrupt |

## Verification
A corrupted register bit shows at once on a static output (`dma_wide`, `pullup_en`, `led_n`) or on the next read response. A stray or missing edge-detect event shows differently. The error stays hidden for the whole delay window and appears only when `resume_out` rises, so the bench checks that output on every cycle of the delay and the pulse. A wrong blink counter or interrupt policy shows within one blink period or one event cycle. The bench sweeps every event combination and every register value in turn.

// File: rtl/usb_mode_pkg.sv
package usb_mode_pkg;

    localparam logic [7:0] CMD_MODE_WR = 8'hB8;
    localparam logic [7:0] CMD_MODE_RD = 8'hB9;

    // Field order matches the bit positions that software decodes.
    typedef struct packed {
        logic dma16;      // bit 7
        logic rsm_req;    // bit 6
        logic sus_req;    // bit 5
        logic spare;      // bit 4
        logic int_en;     // bit 3
        logic dbg;        // bit 2
        logic blink_off;  // bit 1
        logic conn;       // bit 0
    } mode_t;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_WAIT  = 2'd1,
        WK_DRIVE = 2'd2
    } wake_st_e;

endpackage

// File: rtl/usb_mode_regs.sv
module usb_mode_regs
    import usb_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic [7:0] cmd_wdata,
    output mode_t      mode,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rsm_fall,
    output logic       sus_fall
);

    typedef struct packed {
        mode_t      mode;
        logic       rd_valid;
        logic [7:0] rd_data;
    } regs_st_t;

    regs_st_t st_d, st_q;
    logic     wr_hit, rd_hit;
    mode_t    wmode;

    always_comb begin
        wmode    = mode_t'(cmd_wdata);
        wr_hit   = cmd_valid && (cmd_code == CMD_MODE_WR);
        rd_hit   = cmd_valid && (cmd_code == CMD_MODE_RD);
        rsm_fall = wr_hit && st_q.mode.rsm_req && !wmode.rsm_req;
        sus_fall = wr_hit && st_q.mode.sus_req && !wmode.sus_req;

        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        if (wr_hit) begin
            st_d.mode = wmode;
        end
        if (rd_hit) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = 8'(st_q.mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/usb_wake_ctl.sv
module usb_wake_ctl
    import usb_mode_pkg::*;
#(
    parameter int DELAY_CYC = 240000,
    parameter int PULSE_CYC = 480000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rsm_fall,
    input  logic sus_fall,
    input  logic resume_in,
    input  logic bus_reset,
    output logic resume_out,
    output logic suspended
);

    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        wake_st_e      st;
        logic [CW-1:0] cnt;
        logic          susp;
    } wake_t;

    wake_t st_d, st_q;
    logic  done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        case (st_q.st)
            WK_IDLE: begin
                if (rsm_fall) begin
                    st_d.st  = WK_WAIT;
                    st_d.cnt = '0;
                end
            end
            WK_WAIT: begin
                if (st_q.cnt == CW'(DELAY_CYC - 1)) begin
                    st_d.st  = WK_DRIVE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            WK_DRIVE: begin
                if (st_q.cnt == CW'(PULSE_CYC - 1)) begin
                    st_d.st  = WK_IDLE;
                    st_d.cnt = '0;
                    done     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: begin
                st_d.st  = WK_IDLE;
                st_d.cnt = '0;
            end
        endcase

        if (sus_fall) begin
            st_d.susp = 1'b1;
        end
        if (resume_in || bus_reset || done) begin
            st_d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: WK_IDLE, cnt: '0, susp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign resume_out = (st_q.st == WK_DRIVE);
    assign suspended  = st_q.susp;

endmodule

// File: rtl/usb_led_blink.sv
module usb_led_blink #(
    parameter int BLINK_CYC = 4800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blink_off,
    input  logic enum_ok,
    input  logic traffic,
    output logic led_n
);

    localparam int BW = $clog2(BLINK_CYC + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          phase;
    } blink_t;

    blink_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (traffic && enum_ok && !blink_off) begin
            if (st_q.cnt == BW'(BLINK_CYC - 1)) begin
                st_d.cnt   = '0;
                st_d.phase = !st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + BW'(1);
            end
        end else begin
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_n = !(enum_ok && (blink_off || !st_q.phase));

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic int_en,
    input  logic dbg,
    input  logic ev_ack,
    input  logic ev_nak,
    input  logic ev_err,
    input  logic ev_iso,
    output logic irq
);

    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t st_d, st_q;
    logic hit;

    always_comb begin
        hit      = dbg ? (ev_nak || ev_err) : (ev_ack || ev_iso);
        st_d.irq = int_en && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/usb_mode_ctl.sv
module usb_mode_ctl
    import usb_mode_pkg::*;
#(
    parameter int CLK_KHZ  = 48000,
    parameter int DELAY_MS = 5,
    parameter int PULSE_MS = 10,
    parameter int BLINK_MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic [7:0] cmd_wdata,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    input  logic       bus_reset,
    input  logic       resume_in,
    input  logic       ext_pullup,
    input  logic       enum_ok,
    input  logic       traffic,
    input  logic       ev_ack,
    input  logic       ev_nak,
    input  logic       ev_err,
    input  logic       ev_iso,
    output logic       dma_wide,
    output logic       pullup_en,
    output logic       resume_out,
    output logic       suspended,
    output logic       led_n,
    output logic       irq
);

    localparam int DELAY_CYC = CLK_KHZ * DELAY_MS;
    localparam int PULSE_CYC = CLK_KHZ * PULSE_MS;
    localparam int BLINK_CYC = CLK_KHZ * BLINK_MS;

    mode_t mode_q;
    logic  rsm_fall, sus_fall;

    usb_mode_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_wdata (cmd_wdata),
        .mode      (mode_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rsm_fall  (rsm_fall),
        .sus_fall  (sus_fall)
    );

    usb_wake_ctl #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) wake_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsm_fall   (rsm_fall),
        .sus_fall   (sus_fall),
        .resume_in  (resume_in),
        .bus_reset  (bus_reset),
        .resume_out (resume_out),
        .suspended  (suspended)
    );

    usb_led_blink #(
        .BLINK_CYC (BLINK_CYC)
    ) led_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .blink_off (mode_q.blink_off),
        .enum_ok   (enum_ok),
        .traffic   (traffic),
        .led_n     (led_n)
    );

    usb_irq_gate irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .int_en (mode_q.int_en),
        .dbg    (mode_q.dbg),
        .ev_ack (ev_ack),
        .ev_nak (ev_nak),
        .ev_err (ev_err),
        .ev_iso (ev_iso),
        .irq    (irq)
    );

    assign dma_wide  = mode_q.dma16;
    assign pullup_en = mode_q.conn && !ext_pullup;

endmodule

// File: rtl/usb_mode_ctl_chk.sv
module usb_mode_ctl_chk
    import usb_mode_pkg::*;
#(
    parameter int PULSE_CYC = 480000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic [7:0] cmd_wdata,
    input logic       bus_reset,
    input logic       ext_pullup,
    input logic [7:0] mode,
    input logic       irq,
    input logic       pullup_en,
    input logic       resume_out,
    input logic       suspended
);

    localparam int HW = $clog2(PULSE_CYC + 1) + 1;

    logic [HW-1:0] hi_cnt;
    logic          wr_now;

    assign wr_now = cmd_valid && (cmd_code == CMD_MODE_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (resume_out) begin
            hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R3: a bus reset without a write leaves the register untouched
    a_r3_bus_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !wr_now) |=> $stable(mode));

    // R4: each resume pulse lasts exactly the configured length
    a_r4_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resume_out) |-> (hi_cnt == HW'(PULSE_CYC)));

    // R5: suspend is entered only through a 1-then-0 write of bit 5
    a_r5_suspend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(wr_now && mode[5] && !cmd_wdata[5]));

    // R6: no interrupt unless enabled at the sampling edge
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mode[3]));

    // R9: external pull-up configuration overrides the connect bit
    a_r9_ext_pullup_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pullup |-> !pullup_en);

endmodule

bind usb_mode_ctl usb_mode_ctl_chk #(
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_wdata  (cmd_wdata),
    .bus_reset  (bus_reset),
    .ext_pullup (ext_pullup),
    .mode       (mode_q),
    .irq        (irq),
    .pullup_en  (pullup_en),
    .resume_out (resume_out),
    .suspended  (suspended)
);

// File: tb/usb_mode_ctl_tb_top.sv
module usb_mode_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ  = 3;
    localparam int D    = KHZ * 5;
    localparam int P    = KHZ * 10;
    localparam int B    = KHZ * 2;
    localparam logic [7:0] WR = 8'hB8;
    localparam logic [7:0] RD = 8'hB9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       bus_reset = 1'b0;
    logic       resume_in = 1'b0;
    logic       ext_pullup = 1'b0;
    logic       enum_ok = 1'b0;
    logic       traffic = 1'b0;
    logic       ev_ack = 1'b0, ev_nak = 1'b0, ev_err = 1'b0, ev_iso = 1'b0;
    logic       dma_wide, pullup_en, resume_out, suspended, led_n, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    usb_mode_ctl #(
        .CLK_KHZ (KHZ), .DELAY_MS (5), .PULSE_MS (10), .BLINK_MS (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_code (cmd_code), .cmd_wdata (cmd_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .bus_reset (bus_reset), .resume_in (resume_in), .ext_pullup (ext_pullup),
        .enum_ok (enum_ok), .traffic (traffic),
        .ev_ack (ev_ack), .ev_nak (ev_nak), .ev_err (ev_err), .ev_iso (ev_iso),
        .dma_wide (dma_wide), .pullup_en (pullup_en), .resume_out (resume_out),
        .suspended (suspended), .led_n (led_n), .irq (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cmd(input logic [7:0] code, input logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_wdata = data;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic read_expect(input string tag, input logic [7:0] exp);
        cmd(RD, 8'h00);
        check({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({tag, " rd_data"}, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual running, expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2: power-on state
        check("R2 resume_out", 32'(resume_out), 32'd0);
        check("R2 suspended", 32'(suspended), 32'd0);
        check("R2 irq", 32'(irq), 32'd0);
        check("R2 pullup_en", 32'(pullup_en), 32'd0);
        check("R2 dma_wide", 32'(dma_wide), 32'd0);
        check("R2 led_n", 32'(led_n), 32'd1);
        check("R2 rd_valid idle", 32'(rd_valid), 32'd0);
        read_expect("R2", 8'h00);

        // R1, R9, R10: every register value written and read back
        for (int v = 0; v < 256; v++) begin
            cmd(WR, 8'(v));
            check("R10 dma_wide", 32'(dma_wide), 32'(v >> 7));
            check("R9 pullup_en", 32'(pullup_en), 32'(v & 1));
            read_expect("R1", 8'(v));
        end

        // R1: foreign codes ignored
        cmd(WR, 8'hAA);
        cmd(8'hBA, 8'h55);
        cmd(8'hB7, 8'h55);
        read_expect("R1 foreign write", 8'hAA);
        cmd(8'hBB, 8'h00);
        check("R1 foreign read", 32'(rd_valid), 32'd0);

        // R3: bus reset keeps the register
        cmd(WR, 8'h9F);
        bus_reset = 1'b1;
        tick(); tick(); tick();
        bus_reset = 1'b0;
        read_expect("R3", 8'h9F);

        // R9: connect bit against external pull-up
        for (int c = 0; c < 2; c++) begin
            for (int e = 0; e < 2; e++) begin
                cmd(WR, 8'(c));
                ext_pullup = e[0];
                #1;
                check("R9 pullup", 32'(pullup_en), 32'(c & (1 - e)));
            end
        end
        ext_pullup = 1'b0;

        // R6, R7: interrupt qualification, all modes and event sets
        for (int m = 0; m < 4; m++) begin
            cmd(WR, 8'((m & 2) << 2 | (m & 1) << 2));
            for (int e = 0; e < 16; e++) begin
                ev_ack = e[0]; ev_nak = e[1]; ev_err = e[2]; ev_iso = e[3];
                tick();
                begin
                    int ie, dg, hit;
                    ie  = (m >> 1) & 1;
                    dg  = m & 1;
                    hit = dg ? (e[1] | e[2]) : (e[0] | e[3]);
                    check(dg ? "R7 irq debug" : "R6 irq", 32'(irq), 32'(ie & hit));
                end
            end
            ev_ack = 0; ev_nak = 0; ev_err = 0; ev_iso = 0;
            tick();
        end

        // R4: resume timing, with a request during the wait ignored
        do_reset();
        cmd(WR, 8'h40);
        cmd(WR, 8'h00);
        check("R4 idle at write", 32'(resume_out), 32'd0);
        for (int n = 1; n <= D + P + 3; n++) begin
            if (n == 3) begin
                cmd_valid = 1'b1; cmd_code = WR; cmd_wdata = 8'h40;
            end else if (n == 4) begin
                cmd_valid = 1'b1; cmd_code = WR; cmd_wdata = 8'h00;
            end else begin
                cmd_valid = 1'b0;
            end
            tick();
            check("R4 resume_out", 32'(resume_out), 32'((n >= D + 2 - 2) && (n < D + P)));
        end
        cmd_valid = 1'b0;
        // R4: clearing a bit that is already 0 starts nothing
        cmd(WR, 8'h00);
        cmd(WR, 8'h00);
        for (int n = 0; n < D + 2; n++) begin
            tick();
            check("R4 no spurious", 32'(resume_out), 32'd0);
        end

        // R5: suspend entry and the three exits
        do_reset();
        cmd(WR, 8'h20);
        check("R5 set alone", 32'(suspended), 32'd0);
        cmd(WR, 8'h00);
        check("R5 enter", 32'(suspended), 32'd1);
        resume_in = 1'b1;
        tick();
        resume_in = 1'b0;
        check("R5 resume_in exit", 32'(suspended), 32'd0);
        cmd(WR, 8'h20);
        cmd(WR, 8'h00);
        check("R5 re-enter", 32'(suspended), 32'd1);
        bus_reset = 1'b1;
        tick();
        bus_reset = 1'b0;
        check("R5 bus_reset exit", 32'(suspended), 32'd0);
        cmd(WR, 8'h20);
        cmd(WR, 8'h00);
        cmd(WR, 8'h40);
        cmd(WR, 8'h00);
        for (int n = 1; n <= D + P; n++) begin
            tick();
            if (n == D + P - 1) check("R5 held during pulse", 32'(suspended), 32'd1);
            if (n == D + P)     check("R5 pulse-end exit", 32'(suspended), 32'd0);
        end

        // R8: link LED
        do_reset();
        traffic = 1'b1;
        tick();
        check("R8 off before enum", 32'(led_n), 32'd1);
        traffic = 1'b0;
        enum_ok = 1'b1;
        tick();
        check("R8 on when idle", 32'(led_n), 32'd0);
        cmd(WR, 8'h02);
        traffic = 1'b1;
        for (int n = 0; n < 3 * B; n++) begin
            tick();
            check("R8 steady on", 32'(led_n), 32'd0);
        end
        traffic = 1'b0;
        cmd(WR, 8'h00);
        tick();
        traffic = 1'b1;
        #1;
        check("R8 blink start", 32'(led_n), 32'd0);
        for (int m = 1; m <= 4 * B; m++) begin
            tick();
            check("R8 blink", 32'(led_n), 32'((m / B) % 2));
        end
        traffic = 1'b0;
        tick();
        check("R8 idle again", 32'(led_n), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule